// File: doc/BRIEF.md
# Polyphonic Envelope Generator Bank

This block drives the amplitude contour of a small polyphonic synthesizer voice pool. Note-on and note-off events arrive on a shared event port with a note number. An allocator binds each new note to one of `NUM_VOICES` envelope generators and forwards it as a start or a release pulse. Each generator then walks attack, decay, sustain and release on its own parameter inputs and presents an unsigned level for the downstream amplifier.

Each generator uses its own rate and sustain inputs. Those inputs are sampled only when a phase begins, so a control sweep never distorts a ramp that is already running. Level updates happen only on a tick from an internal clock divider. Note events are acted on in the clock cycle they arrive.

When the pool is full, a new note may take over a voice that is already releasing. A voice whose key is still down is never taken. If every voice is held, the new note is dropped and the oldest notes keep sounding.

Top module: `env_bank`

## Requirements
- R1: A note-on whose note number matches no active voice goes to the lowest-indexed idle voice. That voice's bit of `gate_o` goes high and its `voice_note_o` field shows the note, both one cycle after the event.
- R2: A note-on whose note number equals that of a voice that is not idle restarts that same voice and allocates nothing new.
- R3: If no voice is idle and no voice matches, the new note takes the releasing voice with the lowest level. On equal levels it takes the lowest index.
- R4: A voice whose gate is high is never reassigned to another note. If all voices are gated and none matches, the note-on has no effect on `gate_o` or `voice_note_o`.
- R5: A note-off clears the gate only of the gated voice holding that note number. A note-off for a note that no gated voice holds changes nothing. A note-on and a note-off in the same cycle act as the note-on alone.
- R6: Levels change only on a divider tick, and ticks come once every `TICK_DIV` clock cycles. A start event is the one exception: it forces the level to zero at once.
- R7: In attack the level rises by the latched attack rate on each tick and saturates at exactly 2^LVL_W-1. The voice then enters decay. A rate of zero leaves the level unchanged.
- R8: The sustain input is widened to the level width by repeating its bits from the MSB down, so 0xFF maps to 0xFFF and 0x80 maps to 0x808 at 12 bits. Decay falls by the decay rate on each tick, clamps at that scaled sustain value, and then holds there.
- R9: Release falls by the release rate on each tick, clamps at zero and returns the voice to idle, which makes it free for allocation. A release rate of zero holds the level.
- R10: A note-off during attack or decay moves the voice straight to release. Release continues from the level the voice had reached.
- R11: A start event on a releasing voice sets the level to zero and restarts attack from the beginning.
- R12: Each phase samples its rate (and, for decay, the sustain value) when it begins. Later changes to those inputs have no effect until the next phase begins.
- R13: After reset every level is zero, every gate is low and every note field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| note_on_i | input | 1 | Note-on event strobe |
| note_off_i | input | 1 | Note-off event strobe |
| note_i | input | NOTE_W | Note number of the event |
| attack_rate_i | input | NUM_VOICES*RATE_W | Per-voice attack increment per tick |
| decay_rate_i | input | NUM_VOICES*RATE_W | Per-voice decay decrement per tick |
| sustain_lvl_i | input | NUM_VOICES*SUS_W | Per-voice sustain level |
| release_rate_i | input | NUM_VOICES*RATE_W | Per-voice release decrement per tick |
| level_o | output | NUM_VOICES*LVL_W | Per-voice envelope level, voice 0 in the low bits |
| gate_o | output | NUM_VOICES | Per-voice key-held flag |
| voice_note_o | output | NUM_VOICES*NOTE_W | Note number bound to each voice |

## Verification
The bench builds the bank with four voices, 12-bit levels, 8-bit rates and sustain, and a divider of 4. With four voices the pool fills after a few events, which brings the dropped-note case and steals by lowest level within a short table of events. The small divider puts tick spacing and per-tick deltas within a few cycles of each other, so the latched increment can be measured directly. The 12-bit level against 8-bit rates makes the attack overshoot full scale, which exercises the saturation, and it makes the sustain widening visible as 0x808. A release rate of zero freezes two releasing voices at the same level, which sets up the tie-break.

// File: rtl/env_bank_pkg.sv
package env_bank_pkg;
  typedef enum logic [2:0] {
    ENV_IDLE,
    ENV_ATTACK,
    ENV_DECAY,
    ENV_SUSTAIN,
    ENV_RELEASE
  } env_state_e;
endpackage

// File: rtl/env_tick.sv
module env_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_in;
      assign unused_in = clk_i ^ rst_ni;
      assign tick_o = 1'b1;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      p_tick_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/env_voice.sv
module env_voice
  import env_bank_pkg::*;
#(
  parameter int unsigned RATE_W = 8,
  parameter int unsigned SUS_W  = 8,
  parameter int unsigned LVL_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              trig_i,
  input  logic              rel_i,
  input  logic [RATE_W-1:0] attack_rate_i,
  input  logic [RATE_W-1:0] decay_rate_i,
  input  logic [SUS_W-1:0]  sustain_lvl_i,
  input  logic [RATE_W-1:0] release_rate_i,
  output logic [LVL_W-1:0]  level_o,
  output logic              busy_o,
  output logic              releasing_o
);
  localparam logic [LVL_W:0] FULL = {1'b0, {LVL_W{1'b1}}};

  env_state_e        state_q;
  logic [LVL_W-1:0]  lvl_q, sus_q, sus_scaled;
  logic [RATE_W-1:0] rate_q;
  logic [LVL_W:0]    step, lvl_ext, sus_ext, up_sum;

  // replicate sustain bits MSB-first to fill the level width
  always_comb begin
    for (int b = 0; b < int'(LVL_W); b++) begin
      sus_scaled[LVL_W-1-b] = sustain_lvl_i[SUS_W-1-(b % SUS_W)];
    end
  end

  assign step    = (LVL_W+1)'(rate_q);
  assign lvl_ext = {1'b0, lvl_q};
  assign sus_ext = {1'b0, sus_q};
  assign up_sum  = lvl_ext + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENV_IDLE;
      lvl_q   <= '0;
      sus_q   <= '0;
      rate_q  <= '0;
    end else if (trig_i) begin
      state_q <= ENV_ATTACK;
      lvl_q   <= '0;
      rate_q  <= attack_rate_i;
    end else if (rel_i && (state_q inside {ENV_ATTACK, ENV_DECAY, ENV_SUSTAIN})) begin
      state_q <= ENV_RELEASE;
      rate_q  <= release_rate_i;
    end else if (tick_i) begin
      case (state_q)
        ENV_ATTACK: begin
          if (up_sum >= FULL) begin
            lvl_q   <= FULL[LVL_W-1:0];
            state_q <= ENV_DECAY;
            rate_q  <= decay_rate_i;
            sus_q   <= sus_scaled;
          end else begin
            lvl_q <= up_sum[LVL_W-1:0];
          end
        end
        ENV_DECAY: begin
          if (lvl_ext <= sus_ext + step) begin
            lvl_q   <= sus_q;
            state_q <= ENV_SUSTAIN;
          end else begin
            lvl_q <= lvl_q - LVL_W'(rate_q);
          end
        end
        ENV_RELEASE: begin
          if (lvl_ext <= step) begin
            lvl_q   <= '0;
            state_q <= ENV_IDLE;
          end else begin
            lvl_q <= lvl_q - LVL_W'(rate_q);
          end
        end
        default: ;
      endcase
    end
  end

  assign level_o     = lvl_q;
  assign busy_o      = (state_q != ENV_IDLE);
  assign releasing_o = (state_q == ENV_RELEASE);

  p_trig_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (lvl_q == '0 && state_q == ENV_ATTACK));
  p_hold_no_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !trig_i) |=> $stable(lvl_q));
  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENV_IDLE) |-> (lvl_q == '0));
  p_attack_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENV_ATTACK && !trig_i) |=> (lvl_q >= $past(lvl_q)));
  p_release_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENV_RELEASE) |=> (lvl_q <= $past(lvl_q)));
  p_sustain_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENV_SUSTAIN && !trig_i && !rel_i) |=> $stable(lvl_q));
endmodule

// File: rtl/env_alloc.sv
module env_alloc #(
  parameter int unsigned NUM_VOICES = 4,
  parameter int unsigned NOTE_W     = 7,
  parameter int unsigned LVL_W      = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         note_on_i,
  input  logic                         note_off_i,
  input  logic [NOTE_W-1:0]            note_i,
  input  logic [NUM_VOICES-1:0]        busy_i,
  input  logic [NUM_VOICES-1:0]        releasing_i,
  input  logic [NUM_VOICES*LVL_W-1:0]  level_i,
  output logic [NUM_VOICES-1:0]        trig_o,
  output logic [NUM_VOICES-1:0]        rel_o,
  output logic [NUM_VOICES-1:0]        held_o,
  output logic [NUM_VOICES*NOTE_W-1:0] note_o
);
  localparam int unsigned IDX_W = (NUM_VOICES > 1) ? $clog2(NUM_VOICES) : 1;

  logic [NOTE_W-1:0]     note_q [NUM_VOICES];
  logic [NUM_VOICES-1:0] held_q;

  logic             hit_ok, free_ok, vic_ok, pick_ok;
  logic [IDX_W-1:0] hit_idx, free_idx, vic_idx, pick_idx;
  logic [LVL_W-1:0] vic_lvl;

  always_comb begin
    hit_ok = 1'b0; hit_idx = '0;
    free_ok = 1'b0; free_idx = '0;
    vic_ok = 1'b0; vic_idx = '0; vic_lvl = '0;
    // descending scan: lowest index wins
    for (int i = NUM_VOICES - 1; i >= 0; i--) begin
      if (busy_i[i] && note_q[i] == note_i) begin
        hit_ok = 1'b1; hit_idx = IDX_W'(i);
      end
      if (!busy_i[i]) begin
        free_ok = 1'b1; free_idx = IDX_W'(i);
      end
    end
    // ascending scan with strict compare: ties keep lowest index
    for (int i = 0; i < int'(NUM_VOICES); i++) begin
      if (releasing_i[i] && (!vic_ok || level_i[i*LVL_W +: LVL_W] < vic_lvl)) begin
        vic_ok  = 1'b1;
        vic_idx = IDX_W'(i);
        vic_lvl = level_i[i*LVL_W +: LVL_W];
      end
    end
    pick_ok  = hit_ok | free_ok | vic_ok;
    pick_idx = hit_ok ? hit_idx : (free_ok ? free_idx : vic_idx);
    trig_o = '0;
    if (note_on_i && pick_ok) trig_o[pick_idx] = 1'b1;
    for (int i = 0; i < int'(NUM_VOICES); i++) begin
      rel_o[i] = note_off_i && !note_on_i && held_q[i] && (note_q[i] == note_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      for (int i = 0; i < int'(NUM_VOICES); i++) note_q[i] <= '0;
    end else begin
      for (int i = 0; i < int'(NUM_VOICES); i++) begin
        if (trig_o[i]) begin
          note_q[i] <= note_i;
          held_q[i] <= 1'b1;
        end else if (rel_o[i]) begin
          held_q[i] <= 1'b0;
        end
      end
    end
  end

  assign held_o = held_q;

  p_one_trig_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trig_o));

  for (genvar g = 0; g < NUM_VOICES; g++) begin : g_out
    assign note_o[g*NOTE_W +: NOTE_W] = note_q[g];

    p_no_steal_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_o[g] && held_q[g]) |-> (note_q[g] == note_i));
    p_rel_held_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rel_o[g] |=> !held_o[g]);
    p_steal_releasing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_o[g] && busy_i[g] && note_q[g] != note_i) |-> releasing_i[g]);
  end
endmodule

// File: rtl/env_bank.sv
module env_bank #(
  parameter int unsigned NUM_VOICES = 4,
  parameter int unsigned NOTE_W     = 7,
  parameter int unsigned RATE_W     = 8,
  parameter int unsigned SUS_W      = 8,
  parameter int unsigned LVL_W      = 12,
  parameter int unsigned TICK_DIV   = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         note_on_i,
  input  logic                         note_off_i,
  input  logic [NOTE_W-1:0]            note_i,
  input  logic [NUM_VOICES*RATE_W-1:0] attack_rate_i,
  input  logic [NUM_VOICES*RATE_W-1:0] decay_rate_i,
  input  logic [NUM_VOICES*SUS_W-1:0]  sustain_lvl_i,
  input  logic [NUM_VOICES*RATE_W-1:0] release_rate_i,
  output logic [NUM_VOICES*LVL_W-1:0]  level_o,
  output logic [NUM_VOICES-1:0]        gate_o,
  output logic [NUM_VOICES*NOTE_W-1:0] voice_note_o
);
  logic                        tick;
  logic [NUM_VOICES-1:0]       busy, releasing, trig, rel;
  logic [NUM_VOICES*LVL_W-1:0] lvl_flat;

  env_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  env_alloc #(
    .NUM_VOICES (NUM_VOICES),
    .NOTE_W     (NOTE_W),
    .LVL_W      (LVL_W)
  ) u_alloc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .note_on_i   (note_on_i),
    .note_off_i  (note_off_i),
    .note_i      (note_i),
    .busy_i      (busy),
    .releasing_i (releasing),
    .level_i     (lvl_flat),
    .trig_o      (trig),
    .rel_o       (rel),
    .held_o      (gate_o),
    .note_o      (voice_note_o)
  );

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    env_voice #(
      .RATE_W (RATE_W),
      .SUS_W  (SUS_W),
      .LVL_W  (LVL_W)
    ) u_voice (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .tick_i         (tick),
      .trig_i         (trig[v]),
      .rel_i          (rel[v]),
      .attack_rate_i  (attack_rate_i[v*RATE_W +: RATE_W]),
      .decay_rate_i   (decay_rate_i[v*RATE_W +: RATE_W]),
      .sustain_lvl_i  (sustain_lvl_i[v*SUS_W +: SUS_W]),
      .release_rate_i (release_rate_i[v*RATE_W +: RATE_W]),
      .level_o        (lvl_flat[v*LVL_W +: LVL_W]),
      .busy_o         (busy[v]),
      .releasing_o    (releasing[v])
    );
  end

  assign level_o = lvl_flat;
endmodule

// File: tb/env_bank_tb_top.sv
module env_bank_tb_top;
  localparam int N = 4, LW = 12, RW = 8, SW = 8, NW = 7, DIV = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic note_on = 1'b0, note_off = 1'b0;
  logic [NW-1:0]   note = '0;
  logic [N*RW-1:0] atk = '0, dec = '0, rls = '0;
  logic [N*SW-1:0] sus = '0;
  logic [N*LW-1:0] level;
  logic [N-1:0]    gate;
  logic [N*NW-1:0] vnote_flat;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  env_bank #(
    .NUM_VOICES(N), .NOTE_W(NW), .RATE_W(RW), .SUS_W(SW), .LVL_W(LW), .TICK_DIV(DIV)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .note_on_i(note_on), .note_off_i(note_off),
    .note_i(note), .attack_rate_i(atk), .decay_rate_i(dec), .sustain_lvl_i(sus),
    .release_rate_i(rls), .level_o(level), .gate_o(gate), .voice_note_o(vnote_flat)
  );

  // {op(1=on,2=off), note, wait, exp gate, exp voice, exp note}
  localparam int NV = 13;
  localparam logic [29:0] VEC [NV] = '{
    {2'd1, 7'd60, 8'd2,   4'b0001, 2'd0, 7'd60},
    {2'd1, 7'd62, 8'd2,   4'b0011, 2'd1, 7'd62},
    {2'd1, 7'd64, 8'd2,   4'b0111, 2'd2, 7'd64},
    {2'd1, 7'd65, 8'd200, 4'b1111, 2'd3, 7'd65},
    {2'd1, 7'd67, 8'd2,   4'b1111, 2'd0, 7'd60},
    {2'd2, 7'd99, 8'd2,   4'b1111, 2'd1, 7'd62},
    {2'd2, 7'd62, 8'd2,   4'b1101, 2'd1, 7'd62},
    {2'd1, 7'd62, 8'd2,   4'b1111, 2'd1, 7'd62},
    {2'd2, 7'd64, 8'd40,  4'b1011, 2'd2, 7'd64},
    {2'd2, 7'd65, 8'd2,   4'b0011, 2'd3, 7'd65},
    {2'd1, 7'd70, 8'd2,   4'b0111, 2'd2, 7'd70},
    {2'd1, 7'd72, 8'd2,   4'b1111, 2'd3, 7'd72},
    {2'd1, 7'd74, 8'd2,   4'b1111, 2'd3, 7'd72}
  };
  localparam string TAG [NV] = '{"R1", "R1", "R1", "R1", "R4", "R5", "R5",
                                 "R2", "R5", "R5", "R3", "R3", "R4"};

  function automatic int lvl(input int v);
    return int'(level[v*LW +: LW]);
  endfunction

  function automatic int vn(input int v);
    return int'(vnote_flat[v*NW +: NW]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_all(input int a, input int d, input int s, input int r);
    for (int v = 0; v < N; v++) begin
      atk[v*RW +: RW] = RW'(a);
      dec[v*RW +: RW] = RW'(d);
      sus[v*SW +: SW] = SW'(s);
      rls[v*RW +: RW] = RW'(r);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; note_on = 1'b0; note_off = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic ev(input bit on, input int n);
    @(negedge clk);
    note = NW'(n); note_on = on; note_off = !on;
    @(negedge clk);
    note_on = 1'b0; note_off = 1'b0;
  endtask

  // first level delta and cycle gap between the first two level changes
  task automatic watch(input int v, input int maxc, output int d, output int gap);
    int prev, t1;
    prev = lvl(v); t1 = -1; d = -1; gap = -1;
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (lvl(v) != prev) begin
        if (t1 < 0) begin
          t1 = c; d = lvl(v) - prev;
        end else begin
          gap = c - t1;
          break;
        end
        prev = lvl(v);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d, gap, l0;
    set_all(255, 255, 8'h80, 1);
    do_reset();
    // R13 reset state
    check(level == '0, "R13", int'(level[LW-1:0]), 0);
    check(gate == '0, "R13", int'(gate), 0);
    check(vnote_flat == '0, "R13", vn(0), 0);

    // allocation table
    for (int k = 0; k < NV; k++) begin
      ev(VEC[k][29:28] == 2'd1, int'(VEC[k][27:21]));
      repeat (int'(VEC[k][20:13])) @(negedge clk);
      check(gate == VEC[k][12:9], TAG[k], int'(gate), int'(VEC[k][12:9]));
      check(vn(int'(VEC[k][8:7])) == int'(VEC[k][6:0]), TAG[k],
            vn(int'(VEC[k][8:7])), int'(VEC[k][6:0]));
    end

    // R12 / R6 / R7: latched attack rate, tick spacing, saturation
    do_reset();
    set_all(10, 255, 8'hFF, 7);
    ev(1'b1, 40);
    atk[RW-1:0] = 8'd200;
    watch(0, 40, d, gap);
    check(d == 10, "R12", d, 10);
    check(gap == DIV, "R6", gap, DIV);
    repeat (2000) @(negedge clk);
    check(lvl(0) == 4095, "R7", lvl(0), 4095);

    // R10: release from attack continues from reached level
    do_reset();
    set_all(20, 255, 8'hFF, 7);
    ev(1'b1, 40);
    repeat (30) @(negedge clk);
    ev(1'b0, 40);
    check(gate[0] == 1'b0, "R10", int'(gate[0]), 0);
    l0 = lvl(0);
    watch(0, 20, d, gap);
    check(d == -7 && l0 > 0, "R10", d, -7);

    // R9: release reaches zero and frees the voice
    repeat (2000) @(negedge clk);
    check(lvl(0) == 0, "R9", lvl(0), 0);
    ev(1'b1, 41);
    check(vn(0) == 41 && gate == 4'b0001, "R9", vn(0), 41);

    // R11: restart from release begins attack at zero
    repeat (3000) @(negedge clk);
    ev(1'b0, 41);
    repeat (20) @(negedge clk);
    check(lvl(0) < 4095, "R11", lvl(0), 4094);
    ev(1'b1, 41);
    check(lvl(0) == 0 && gate[0], "R11", lvl(0), 0);
    watch(0, 20, d, gap);
    check(d == 20, "R11", d, 20);

    // R8: decay settles at widened sustain
    do_reset();
    set_all(255, 100, 8'h80, 1);
    ev(1'b1, 50);
    repeat (400) @(negedge clk);
    check(lvl(0) == 12'h808, "R8", lvl(0), 12'h808);

    // R3 tie: two releasing voices frozen at equal level, lowest index taken
    do_reset();
    set_all(255, 255, 8'h80, 0);
    ev(1'b1, 1); ev(1'b1, 2); ev(1'b1, 3); ev(1'b1, 4);
    repeat (200) @(negedge clk);
    ev(1'b0, 3);
    ev(1'b0, 2);
    repeat (10) @(negedge clk);
    check(lvl(1) == lvl(2), "R3", lvl(1), lvl(2));
    ev(1'b1, 9);
    check(vn(1) == 9, "R3", vn(1), 9);
    check(vn(2) == 3 && gate == 4'b1011, "R3", int'(gate), 4'b1011);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule